// File: doc/BRIEF.md
# Configuration Scrub Cycle Sequencer

This block rewrites an FPGA's configuration memory by replaying a partial configuration image, held in an external flash, into the device's byte-wide parallel configuration port. Replaying the image overwrites any configuration bits that a radiation upset has flipped. The image is an opaque stream of bytes. Software gives its flash start address and its length in words. A start command with a run mode launches the run, and an abort command ends it.

Three run modes exist. A once run does one pass. A counted run does a given number of passes. A continuous run repeats passes until an abort arrives. Passes follow each other with no idle cycle in between. The block counts finished passes and reports busy, a one-cycle done pulse at the end of a run, and an error flag for rejected requests.

The state machine has three states:
- `ST_IDLE` waits for a command.
- `ST_FETCH` holds a flash read request until the flash returns data.
- `ST_PUSH` drives one configuration write strobe.

Its transitions are:
- idle→fetch on an accepted start.
- fetch→push on flash ready.
- push→fetch for the next word of the same pass (step).
- push→fetch for the first word of the next pass (wrap).
- push→idle when the run finishes.

Top module: `scrub_seq`

## Requirements
- R1: After reset the block is idle, with these values:
  - `busy`, `done`, `fl_rd` and `err_cfg` are 0.
  - `cfg_cs_n` and `cfg_wr_n` are 1.
  - `cycles_done` is 0.
- R2: Each pass reads flash addresses `img_base` through `img_base+img_len-1` in ascending order. It writes each returned byte to `cfg_d` in the same order. `img_base` and `img_len` are captured when a start is accepted.
- R3: A configuration write strobe is issued only for data the flash has marked ready. During the strobe, `cfg_cs_n` and `cfg_wr_n` are both low, for exactly one clock per word. `fl_rd` and `fl_addr` stay steady until `fl_ready` is seen.
- R4: In mode 0 (once), exactly one pass runs. When it ends, `busy` falls and `done` pulses for one cycle. Mode 3 behaves like mode 0.
- R5: In mode 2 (counted), exactly `cmd_count` passes run, and then the run ends.
- R6: In mode 1 (continuous), passes repeat until `cmd_abort`. The abort takes effect at the end of the current pass, so the total is the passes already completed plus one. This includes an abort that arrives on the cycle of the last word's strobe.
- R7: Passes run back to back. On the cycle after the last word's strobe of a pass that does not end the run, `fl_rd` is high and `fl_addr` equals the base address.
- R8: `cycles_done` is cleared when a start is accepted. It then increases by one per finished pass and holds its value after the run ends.
- R9: Some start requests are ignored and set `err_cfg`, and `busy` stays 0. This happens for a counted start with `cmd_count` = 0, and for any start with `img_len` = 0. The next accepted start clears `err_cfg`.
- R10: While busy, `cmd_start` has no effect. While idle, `cmd_abort` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start command pulse |
| cmd_mode | input | 2 | Run mode: 0 once, 1 continuous, 2 counted, 3 as once |
| cmd_abort | input | 1 | Abort command pulse |
| cmd_count | input | CW | Pass count for counted mode |
| img_base | input | AW | Flash start address of the image |
| img_len | input | LW | Image length in words |
| fl_addr | output | AW | Flash read address |
| fl_rd | output | 1 | Flash read request |
| fl_data | input | DW | Flash read data |
| fl_ready | input | 1 | Flash data valid |
| cfg_d | output | DW | Configuration port data |
| cfg_cs_n | output | 1 | Configuration port chip select, active low |
| cfg_wr_n | output | 1 | Configuration port write strobe, active low |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at run end |
| err_cfg | output | 1 | Sticky flag for a rejected start |
| cycles_done | output | CW | Passes finished in the current or last run |

## Verification
Two events can fall in the same cycle: an abort command and the strobe of a pass's last word. Both decide whether the run continues. The bench provokes this by watching for the strobe of the final word and raising `cmd_abort` in that very cycle. It then judges the result by three things: no further pass starts, `cycles_done` equals the completed passes plus one, and exactly one done pulse appears. A second coincidence is a start arriving while a run is busy. The bench judges it by checking that the byte stream still follows the original image.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
    localparam logic [1:0] MODE_ONCE    = 2'd0;
    localparam logic [1:0] MODE_FOREVER = 2'd1;
    localparam logic [1:0] MODE_COUNTED = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_PUSH  = 2'd2
    } scrub_state_t;
endpackage

// File: rtl/scrub_addr_gen.sv
module scrub_addr_gen #(
    parameter int AW = 16,
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          wrap,
    input  logic          step,
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] len,
    output logic [AW-1:0] addr,
    output logic          last
);
    logic [AW-1:0] base_q;
    logic [AW-1:0] addr_q;
    logic [LW-1:0] len_q;
    logic [LW-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            addr_q <= '0;
            len_q  <= '0;
            idx_q  <= '0;
        end else if (arm) begin
            base_q <= base;
            addr_q <= base;
            len_q  <= len;
            idx_q  <= '0;
        end else if (wrap) begin
            addr_q <= base_q;
            idx_q  <= '0;
        end else if (step) begin
            addr_q <= addr_q + AW'(1);
            idx_q  <= idx_q + LW'(1);
        end
    end

    assign addr = addr_q;
    assign last = (idx_q == (len_q - LW'(1)));
endmodule

// File: rtl/scrub_pass_ctr.sv
module scrub_pass_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          bump,
    input  logic [CW-1:0] target,
    output logic [CW-1:0] count,
    output logic          at_goal
);
    logic [CW-1:0] count_q;
    logic [CW-1:0] target_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            target_q <= '0;
        end else if (clear) begin
            count_q  <= '0;
            target_q <= target;
        end else if (bump) begin
            count_q  <= count_q + CW'(1);
        end
    end

    assign count   = count_q;
    assign at_goal = ((count_q + CW'(1)) == target_q);
endmodule

// File: rtl/scrub_seq.sv
module scrub_seq
    import scrub_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int LW = 12,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_start,
    input  logic [1:0]    cmd_mode,
    input  logic          cmd_abort,
    input  logic [CW-1:0] cmd_count,
    input  logic [AW-1:0] img_base,
    input  logic [LW-1:0] img_len,
    output logic [AW-1:0] fl_addr,
    output logic          fl_rd,
    input  logic [DW-1:0] fl_data,
    input  logic          fl_ready,
    output logic [DW-1:0] cfg_d,
    output logic          cfg_cs_n,
    output logic          cfg_wr_n,
    output logic          busy,
    output logic          done,
    output logic          err_cfg,
    output logic [CW-1:0] cycles_done
);
    scrub_state_t st_q, st_d;

    logic [1:0]    mode_q;
    logic          abort_pend_q;
    logic [DW-1:0] data_q;
    logic          last_word;
    logic          at_goal;
    logic          req_bad;
    logic          accept;
    logic          reject;
    logic          pass_end;
    logic          stop_run;
    logic          do_wrap;
    logic          do_step;
    logic          single_like;

    // request screening
    assign req_bad = (img_len == '0) ||
                     ((cmd_mode == MODE_COUNTED) && (cmd_count == '0));
    assign accept  = cmd_start && (st_q == ST_IDLE) && !req_bad;
    assign reject  = cmd_start && (st_q == ST_IDLE) && req_bad;

    // end-of-pass decision
    assign single_like = (mode_q != MODE_FOREVER) && (mode_q != MODE_COUNTED);
    assign pass_end    = (st_q == ST_PUSH) && last_word;
    assign stop_run    = pass_end &&
                         (single_like ||
                          ((mode_q == MODE_COUNTED) && at_goal) ||
                          abort_pend_q || cmd_abort);
    assign do_wrap     = pass_end && !stop_run;
    assign do_step     = (st_q == ST_PUSH) && !last_word;

    scrub_addr_gen #(.AW(AW), .LW(LW)) u_addr (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (accept),
        .wrap (do_wrap),
        .step (do_step),
        .base (img_base),
        .len  (img_len),
        .addr (fl_addr),
        .last (last_word)
    );

    scrub_pass_ctr #(.CW(CW)) u_pass (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .bump   (pass_end),
        .target (cmd_count),
        .count  (cycles_done),
        .at_goal(at_goal)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (accept)   st_d = ST_FETCH;
            ST_FETCH: if (fl_ready) st_d = ST_PUSH;
            ST_PUSH:  st_d = stop_run ? ST_IDLE : ST_FETCH;
            default:  st_d = ST_IDLE;
        endcase
    end

    // run context, data capture and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q       <= MODE_ONCE;
            abort_pend_q <= 1'b0;
            err_cfg      <= 1'b0;
            done         <= 1'b0;
            data_q       <= '0;
        end else begin
            done <= stop_run;
            if (accept) begin
                mode_q       <= cmd_mode;
                abort_pend_q <= 1'b0;
                err_cfg      <= 1'b0;
            end else begin
                if (reject) err_cfg <= 1'b1;
                if (stop_run)
                    abort_pend_q <= 1'b0;
                else if (cmd_abort && (st_q != ST_IDLE))
                    abort_pend_q <= 1'b1;
            end
            if ((st_q == ST_FETCH) && fl_ready) data_q <= fl_data;
        end
    end

    // outputs
    always_comb begin
        fl_rd    = 1'b0;
        cfg_cs_n = 1'b1;
        cfg_wr_n = 1'b1;
        busy     = 1'b1;
        unique case (st_q)
            ST_IDLE:  busy = 1'b0;
            ST_FETCH: fl_rd = 1'b1;
            ST_PUSH: begin
                cfg_cs_n = 1'b0;
                cfg_wr_n = 1'b0;
            end
            default:  busy = 1'b0;
        endcase
    end

    assign cfg_d = data_q;
endmodule

// File: rtl/scrub_seq_chk.sv
module scrub_seq_chk #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_start,
    input logic [1:0]    cmd_mode,
    input logic          cmd_abort,
    input logic [CW-1:0] cmd_count,
    input logic [AW-1:0] fl_addr,
    input logic          fl_rd,
    input logic          fl_ready,
    input logic          cfg_cs_n,
    input logic          cfg_wr_n,
    input logic          busy,
    input logic          done,
    input logic          err_cfg,
    input logic [CW-1:0] cycles_done
);
    assert_strobe_one_clk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_n |=> cfg_wr_n);

    assert_write_after_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_n |-> ($past(fl_rd) && $past(fl_ready) && !cfg_cs_n));

    assert_read_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_rd && !fl_ready) |=> (fl_rd && $stable(fl_addr)));

    assert_done_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_abort_deferred_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_rd && cmd_abort) |=> busy);

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
            ((cycles_done == $past(cycles_done)) ||
             (cycles_done == $past(cycles_done) + CW'(1))));

    assert_zero_count_rejected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_start && (cmd_mode == 2'd2) && (cmd_count == '0)) |=>
            (err_cfg && !busy));

    assert_idle_abort_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_abort && !cmd_start) |=> !busy);
endmodule

bind scrub_seq scrub_seq_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .cmd_mode   (cmd_mode),
    .cmd_abort  (cmd_abort),
    .cmd_count  (cmd_count),
    .fl_addr    (fl_addr),
    .fl_rd      (fl_rd),
    .fl_ready   (fl_ready),
    .cfg_cs_n   (cfg_cs_n),
    .cfg_wr_n   (cfg_wr_n),
    .busy       (busy),
    .done       (done),
    .err_cfg    (err_cfg),
    .cycles_done(cycles_done)
);

// File: tb/sim_scrub_seq.sv
module sim_scrub_seq;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int LW = 12;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_start = 1'b0;
    logic [1:0]    cmd_mode = 2'd0;
    logic          cmd_abort = 1'b0;
    logic [CW-1:0] cmd_count = '0;
    logic [AW-1:0] img_base = '0;
    logic [LW-1:0] img_len = '0;
    logic [AW-1:0] fl_addr;
    logic          fl_rd;
    logic [DW-1:0] fl_data = '0;
    logic          fl_ready = 1'b0;
    logic [DW-1:0] cfg_d;
    logic          cfg_cs_n;
    logic          cfg_wr_n;
    logic          busy;
    logic          done;
    logic          err_cfg;
    logic [CW-1:0] cycles_done;

    always #2.5 clk = ~clk;

    scrub_seq #(.AW(AW), .DW(DW), .LW(LW), .CW(CW)) u0 (.*);

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int max_lat = 3;
    int lat_cur = 0;
    int wait_cnt = 0;

    // expected-stream bookkeeping
    logic [AW-1:0] exp_base = '0;
    int exp_len = 1;
    int widx = 0;
    int passes = 0;
    int done_cnt = 0;
    bit gap_pend = 0;
    bit prev_strobe = 0;

    function automatic logic [DW-1:0] fdata(logic [AW-1:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_up();
        end
    end

    // flash model
    always @(negedge clk) begin
        if (fl_rd) begin
            if (wait_cnt >= lat_cur) begin
                fl_ready = 1'b1;
                fl_data  = fdata(fl_addr);
            end else begin
                fl_ready = 1'b0;
                wait_cnt++;
            end
        end else begin
            fl_ready = 1'b0;
            wait_cnt = 0;
            lat_cur  = (max_lat == 0) ? 0 : int'($urandom % (max_lat + 1));
        end
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (gap_pend) begin
                gap_pend = 0;
                if (busy)
                    check(fl_rd && (fl_addr == exp_base), "R7 back-to-back restart",
                          int'(fl_addr), int'(exp_base));
            end
            if (done) done_cnt++;
            if (!cfg_wr_n) begin
                check(!prev_strobe, "R3 single-clock strobe", 1, 0);
                check(cfg_d == fdata(exp_base + AW'(widx)), "R2 byte order",
                      int'(cfg_d), int'(fdata(exp_base + AW'(widx))));
                widx++;
                if (widx == exp_len) begin
                    widx = 0;
                    passes++;
                    gap_pend = 1;
                end
            end
            prev_strobe = !cfg_wr_n;
        end
    end

    task automatic pulse_start(logic [1:0] m, logic [AW-1:0] b, int l, int c);
        @(posedge clk); #1;
        cmd_mode  = m;
        img_base  = b;
        img_len   = LW'(l);
        cmd_count = CW'(c);
        cmd_start = 1'b1;
        @(posedge clk); #1;
        cmd_start = 1'b0;
    endtask

    task automatic begin_run(logic [1:0] m, logic [AW-1:0] b, int l, int c);
        exp_base = b;
        exp_len  = l;
        widx     = 0;
        passes   = 0;
        done_cnt = 0;
        pulse_start(m, b, l, c);
        check(busy == 1'b1, "R4 busy after start", int'(busy), 1);
        check(cycles_done == '0, "R8 count cleared at start", int'(cycles_done), 0);
        check(err_cfg == 1'b0, "R9 error cleared by accepted start", int'(err_cfg), 0);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
        @(negedge clk);
    endtask

    task automatic end_checks(int exp_total, string req);
        check(busy == 1'b0, req, int'(busy), 0);
        check(passes == exp_total, req, passes, exp_total);
        check(int'(cycles_done) == exp_total, "R8 completed pass count", int'(cycles_done), exp_total);
        check(done_cnt == 1, "R4 single done pulse", done_cnt, 1);
    endtask

    task automatic abort_now(output int exp_total);
        exp_total = passes + 1;
        cmd_abort = 1'b1;
        @(posedge clk); #1;
        cmd_abort = 1'b0;
    endtask

    initial begin
        int expt;
        void'($urandom(32'd4242));
        #12;
        @(negedge clk);
        check(!busy && !done && !fl_rd && !err_cfg, "R1 reset idle", int'(busy), 0);
        check(cfg_cs_n && cfg_wr_n, "R1 reset strobes high", int'(cfg_wr_n), 1);
        check(cycles_done == '0, "R1 reset count", int'(cycles_done), 0);
        rst_n = 1'b1;

        // directed: once
        begin_run(2'd0, 16'h0100, 5, 0);
        wait_idle();
        end_checks(1, "R4 once mode");

        // directed: counted, length 1, zero latency
        max_lat = 0;
        begin_run(2'd2, 16'h2000, 1, 3);
        wait_idle();
        end_checks(3, "R5 counted len1");

        // directed: abort on the last-word strobe
        begin_run(2'd1, 16'h0040, 4, 0);
        for (int i = 0; i < 1000; i++) begin
            @(posedge clk); #1;
            if (!cfg_wr_n && widx == exp_len - 1 && passes >= 1) break;
        end
        abort_now(expt);
        wait_idle();
        end_checks(expt, "R6 abort on last word");

        // directed: rejected starts
        pulse_start(2'd2, 16'h0010, 4, 0);
        check(!busy && err_cfg, "R9 zero count rejected", int'(err_cfg), 1);
        pulse_start(2'd0, 16'h0010, 0, 1);
        check(!busy && err_cfg, "R9 zero length rejected", int'(busy), 0);

        // directed: idle abort, then start while busy
        @(posedge clk); #1;
        cmd_abort = 1'b1;
        @(posedge clk); #1;
        cmd_abort = 1'b0;
        check(busy == 1'b0, "R10 idle abort ignored", int'(busy), 0);
        max_lat = 3;
        begin_run(2'd2, 16'h0300, 6, 2);
        repeat (4) @(posedge clk);
        pulse_start(2'd0, 16'h7000, 2, 1);
        wait_idle();
        end_checks(2, "R10 busy start ignored");

        // random runs
        for (int k = 0; k < 10; k++) begin
            int m;
            int l;
            int c;
            logic [AW-1:0] b;
            m = int'($urandom % 3);
            l = 1 + int'($urandom % 12);
            c = 1 + int'($urandom % 4);
            b = AW'($urandom);
            begin_run(2'(m), b, l, c);
            if (m == 1) begin
                repeat (5 + int'($urandom % 80)) @(posedge clk);
                #1;
                abort_now(expt);
                wait_idle();
                end_checks(expt, "R6 continuous abort");
            end else begin
                wait_idle();
                end_checks((m == 2) ? c : 1, (m == 2) ? "R5 counted mode" : "R4 once mode");
            end
        end

        finish_up();
    end
endmodule